// File: doc/BRIEF.md
# Three-Mode General-Purpose Timer Channel

This block is one timer channel built around a single counter. The same counter serves three modes. In waveform mode the channel drives a pulse train onto its pin: the pin is high for a programmed width and low for the rest of a programmed period. In capture mode the pin is an input, and the channel measures the high time of the incoming signal and the spacing between its rising edges. In event mode the pin is also an input, and the channel counts its rising edges and signals after a programmed number of them.

The pin's direction follows the mode. The output enable is asserted only while the channel is enabled in waveform mode. Each mode ends its unit of work with a one-cycle interrupt pulse: a finished period in waveform mode, a completed input period in capture mode, or a reached edge count in event mode. The pin input passes through a synchronizer before any edge is detected. Clearing the enable stops and zeroes the counter, clears the error flag and releases the pin.

Top module: `gp_timer_chan`

## Requirements
- R1: While `rst` is high, `count_o`, `cap_period_o`, `cap_width_o`, `err_o`, `irq_o`, `pin_out` and `pin_oe` are all zero after the next clock edge.
- R2: `mode_i` is encoded as 2'b00 idle, 2'b01 waveform, 2'b10 capture and 2'b11 event. `pin_oe` is 1 only while `en_i` is high with waveform mode selected, one clock after the selection. `pin_out` is 0 whenever `pin_oe` is 0.
- R3: In waveform mode with `period_i` = P ≥ 1 and `width_i` = W, each period lasts P clock cycles, and `pin_out` is high for min(W, P) of those cycles.
- R4: In waveform mode `irq_o` pulses for one cycle once per period, so that pulses are P cycles apart.
- R5: In capture mode, on each rising edge after the first one since enable, `cap_period_o` takes the number of clock cycles since the previous rising edge. On each falling edge after an armed rising edge, `cap_width_o` takes the number of cycles the pin was high. The first rising edge after enable only arms the measurement.
- R6: In capture mode `irq_o` pulses once for each completed input period, which is every rising edge except the arming one.
- R7: In event mode the counter advances on each synchronized rising edge of `pin_in`. When it reaches `period_i`−1 on an edge, it returns to 0 and `irq_o` pulses. `count_o` therefore equals the edge count modulo P.
- R8: In capture mode, when the counter wraps past its all-ones value, `err_o` is set and `irq_o` pulses. `err_o` then stays set while `en_i` remains high.
- R9: With `en_i` low, after one clock `count_o` is 0, `err_o` is 0, `irq_o` is 0 and `pin_oe` is 0. The captured period and width values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Mode select (00 idle, 01 waveform, 10 capture, 11 event) |
| period_i | input | CNT_W | Period length (waveform) or edge count (event) |
| width_i | input | CNT_W | High time in waveform mode |
| count_o | output | CNT_W | Current counter value |
| cap_period_o | output | CNT_W | Last captured input period in cycles |
| cap_width_o | output | CNT_W | Last captured input high time in cycles |
| err_o | output | 1 | Capture overflow flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pin_in | input | 1 | Pin input value |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The capture overflow is the hardest case to reach. It requires the counter to run through its whole range with no rising edge to restart it. The bench builds the channel with an 8-bit counter and holds the pin low in capture mode for longer than 256 cycles, which makes a single wrap happen in a short run. Capture and event checks depend only on differences between edge times, so the synchronizer latency cancels out. The bench sweeps every small high/low combination and every small period, and computes the expected width, period, interrupt count and residual count from that arithmetic.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    GPT_IDLE = 2'b00,
    GPT_WAVE = 2'b01,
    GPT_CAPT = 2'b10,
    GPT_EVNT = 2'b11
  } gpt_mode_e;
endpackage

// File: rtl/gpt_insync.sv
module gpt_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_period_o,
  output logic [CNT_W-1:0] cap_width_o,
  output logic             err_o,
  output logic             irq_o,
  output logic             pin_out,
  output logic             pin_oe
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] last_val;
  logic             armed_q;

  assign last_val = period_i - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o      <= '0;
      cap_period_o <= '0;
      cap_width_o  <= '0;
      err_o        <= 1'b0;
      irq_o        <= 1'b0;
      pin_out      <= 1'b0;
      pin_oe       <= 1'b0;
      armed_q      <= 1'b0;
    end else if (!en_i) begin
      count_o <= '0;
      err_o   <= 1'b0;
      irq_o   <= 1'b0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pin_oe  <= (mode_i == GPT_WAVE);
      pin_out <= 1'b0;
      irq_o   <= 1'b0;
      case (mode_i)
        GPT_WAVE: begin
          pin_out <= (count_o < width_i);
          if (count_o >= last_val) begin
            count_o <= '0;
            irq_o   <= 1'b1;
          end else begin
            count_o <= count_o + ONE;
          end
        end
        GPT_CAPT: begin
          if (rise_i) begin
            count_o <= ONE;
            armed_q <= 1'b1;
            if (armed_q) begin
              cap_period_o <= count_o;
              irq_o        <= 1'b1;
            end
          end else begin
            if (fall_i && armed_q) cap_width_o <= count_o;
            if (count_o == MAX) begin
              count_o <= '0;
              err_o   <= 1'b1;
              irq_o   <= 1'b1;
            end else begin
              count_o <= count_o + ONE;
            end
          end
        end
        GPT_EVNT: begin
          if (rise_i) begin
            if (count_o >= last_val) begin
              count_o <= '0;
              irq_o   <= 1'b1;
            end else begin
              count_o <= count_o + ONE;
            end
          end
        end
        default: count_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_period_o,
  output logic [CNT_W-1:0] cap_width_o,
  output logic             err_o,
  output logic             irq_o,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe
);
  logic pin_rise, pin_fall;

  gpt_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (pin_in),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .mode_i       (mode_i),
    .period_i     (period_i),
    .width_i      (width_i),
    .rise_i       (pin_rise),
    .fall_i       (pin_fall),
    .count_o      (count_o),
    .cap_period_o (cap_period_o),
    .cap_width_o  (cap_width_o),
    .err_o        (err_o),
    .irq_o        (irq_o),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] count_o,
  input logic             err_o,
  input logic             irq_o,
  input logic             pin_out,
  input logic             pin_oe
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  assert_drive_needs_oe_R2: assert property (@(posedge clk) disable iff (rst)
    pin_out |-> pin_oe);

  assert_oe_only_wave_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i != 2'b01) |=> !pin_oe);

  assert_wave_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i == 2'b01 && period_i != ZERO && count_o < period_i)
      |=> (count_o < $past(period_i)));

  assert_event_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && mode_i == 2'b11 && period_i != ZERO && count_o < period_i)
      |=> (count_o < $past(period_i)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err_o && en_i) |=> err_o);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (count_o == ZERO && !err_o && !pin_oe && !irq_o));
endmodule

bind gp_timer_chan gpt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_i     (en_i),
  .mode_i   (mode_i),
  .period_i (period_i),
  .count_o  (count_o),
  .err_o    (err_o),
  .irq_o    (irq_o),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe)
);

// File: tb/gp_timer_chan_bench.sv
`timescale 1ns/1ps
module gp_timer_chan_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] width_i = '0;
  logic [W-1:0] count_o, cap_period_o, cap_width_o;
  logic         err_o, irq_o, pin_in, pin_out, pin_oe;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gp_timer_chan #(.CNT_W(W)) u_gp_timer_chan (
    .clk(clk), .rst(rst), .en_i(en_i), .mode_i(mode_i),
    .period_i(period_i), .width_i(width_i), .count_o(count_o),
    .cap_period_o(cap_period_o), .cap_width_o(cap_width_o),
    .err_o(err_o), .irq_o(irq_o), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_off();
    @(negedge clk);
    en_i = 1'b0; pin_in = 1'b0; mode_i = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  // R3, R4: waveform sweep
  task automatic run_wave(input int p, input int w);
    int highs = 0, irqs = 0;
    period_i = W'(p); width_i = W'(w); mode_i = 2'b01; en_i = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4 * p; c++) begin
      @(negedge clk);
      if (pin_out) highs++;
      if (irq_o) irqs++;
    end
    check(highs == 4 * ((w < p) ? w : p), "R3 wave high cycles", highs, 4 * ((w < p) ? w : p));
    check(irqs == 4, "R4 wave irq per period", irqs, 4);
    check(pin_oe == 1'b1, "R2 oe in wave", pin_oe, 1);
    idle_off();
  endtask

  // R5, R6: capture sweep
  task automatic run_capt(input int h, input int l);
    int irqs = 0;
    mode_i = 2'b10; en_i = 1'b1; pin_in = 1'b0;
    for (int r = 0; r < 4; r++) begin
      pin_in = 1'b1;
      for (int c = 0; c < h; c++) begin @(negedge clk); if (irq_o) irqs++; end
      pin_in = 1'b0;
      for (int c = 0; c < l; c++) begin @(negedge clk); if (irq_o) irqs++; end
    end
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (irq_o) irqs++; end
    check(cap_width_o == W'(h), "R5 capture width", cap_width_o, h);
    check(cap_period_o == W'(h + l), "R5 capture period", cap_period_o, h + l);
    check(irqs == 3, "R6 capture irq count", irqs, 3);
    check(pin_oe == 1'b0 && pin_out == 1'b0, "R2 capture pin released", pin_oe, 0);
    idle_off();
    check(cap_width_o == W'(h), "R9 capture kept after disable", cap_width_o, h);
  endtask

  // R7: event sweep
  task automatic run_evnt(input int p, input int k);
    int irqs = 0;
    period_i = W'(p); mode_i = 2'b11; en_i = 1'b1; pin_in = 1'b0;
    for (int r = 0; r < k; r++) begin
      pin_in = 1'b1;
      repeat (2) begin @(negedge clk); if (irq_o) irqs++; end
      pin_in = 1'b0;
      repeat (2) begin @(negedge clk); if (irq_o) irqs++; end
    end
    for (int c = 0; c < 6; c++) begin @(negedge clk); if (irq_o) irqs++; end
    check(irqs == k / p, "R7 event irq count", irqs, k / p);
    check(count_o == W'(k % p), "R7 event residual count", count_o, k % p);
    check(pin_oe == 1'b0, "R2 event pin input", pin_oe, 0);
    @(negedge clk); en_i = 1'b0;
    @(negedge clk);
    check(count_o == '0 && pin_oe == 1'b0 && irq_o == 1'b0, "R9 disable clears count", count_o, 0);
    idle_off();
  endtask

  initial begin
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
    check(count_o == '0 && cap_period_o == '0 && cap_width_o == '0 && !err_o && !irq_o && !pin_out && !pin_oe,
          "R1 reset state", count_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int p = 2; p <= 6; p++)
      for (int w = 0; w <= p + 1; w++) run_wave(p, w);

    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++) run_capt(h, l);

    for (int p = 1; p <= 5; p++) begin
      run_evnt(p, 2 * p + 1);
      run_evnt(p, 3 * p);
    end

    // R8: capture overflow with pin held low
    begin
      int irqs = 0;
      mode_i = 2'b10; en_i = 1'b1; pin_in = 1'b0;
      for (int c = 0; c < 300; c++) begin @(negedge clk); if (irq_o) irqs++; end
      check(err_o == 1'b1, "R8 overflow sets error", err_o, 1);
      check(irqs == 1, "R8 overflow irq count", irqs, 1);
      @(negedge clk); en_i = 1'b0;
      @(negedge clk);
      check(err_o == 1'b0, "R9 disable clears error", err_o, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule